// File: doc/BRIEF.md
# Serial Command Shift Front End

This block is the slave side of a three-wire serial link framed by an active-low chip select. A host clocks in an 8-bit op-code and an 8-bit address field, followed by a 16-bit data word for writes. The block decodes the op-code into one of seven commands and passes the command, its address and its data to a separate command executor as a one-cycle strobe. The serial clock, chip select and data input are synchronised into a fast system clock domain, and every serial edge is detected there. The block never uses the serial clock as a clock.

For reads, the block presents a memory address and takes back a 16-bit word one system clock later. It shifts that word out most significant bit first, starting at the 17th falling serial edge. If the host keeps clocking, the block moves on to the next address, and the address wraps from the top of the space back to zero. After a write that the executor accepts, the output line reports the executor's busy flag as a ready/busy level. The output stays in high impedance at all other times.

States: IDLE (chip select high), HEADER (collecting op-code and address), DATA (collecting a write word), READ (shifting read words out), STATUS (driving ready/busy), SKIP (frame done or ignored; wait for chip select high). Transitions: IDLE→HEADER on chip select low; HEADER→READ, →DATA or →SKIP at the 16th rising edge, according to the decoded op-code; DATA→STATUS or →SKIP at the 32nd rising edge, according to `wr_allowed`; STATUS→HEADER on a rising edge with data input 1; any state→IDLE on chip select high.

Top module: `serial_cmd_if`

## Requirements
- R1: The data input is captured only on rising serial-clock edges. Read data on `sdo` changes only after falling serial-clock edges.
- R2: A frame is 8 op-code bits, then 8 address bits, both MSB first. With ADDR_W=8 the address is the whole field. With ADDR_W=7 it is the upper 7 bits of the field and the last bit is padding. Only a write takes a further 16 data bits, MSB first.
- R3: Op-codes map to `cmd_op` codes as follows: 8'hA8 read→0, 8'hA4 write→1, 8'hA3 write-enable→2, 8'hA0 write-disable→3, 8'hAC power-down→4, 8'hA6 power-up→5, 8'hA2 call→6. For every command except write, `cmd_valid` pulses for exactly one cycle after the 16th rising edge, with `cmd_addr` taken from the address field.
- R4: Op-code 8'hAF and any op-code not listed in R3 produce no `cmd_valid` for the rest of the frame.
- R5: For every command except write, the bits clocked in after the 16th rising edge cause no further command in that frame.
- R6: On a read, `sdo_oe` stays 0 through the 16th falling edge. From the 17th falling edge on, `sdo_oe` is 1 and `sdo` carries the word at `rd_addr`, MSB first. `rd_data` must be valid one clock after `rd_addr` changes.
- R7: Further serial clocks after a read word fetch and shift out the word at the next address. The address after the top address (all ones) is 0.
- R8: A write strobes `cmd_valid` with code 1, its address and its 16-bit data after the 32nd rising edge. If `wr_allowed` is 1, `sdo_oe` then goes to 1 and `sdo` shows the inverse of `busy` (0 busy, 1 ready).
- R9: The ready/busy output ends when chip select goes high, or at a rising edge that captures a 1. That captured 1 is taken as the first bit of a new op-code.
- R10: A write issued while `wr_allowed` is 0 still strobes the command, but `sdo_oe` stays 0.
- R11: Raising chip select drops `sdo_oe` within SYNC_STAGES+2 clocks and discards any partial frame. The next frame decodes from its first bit.
- R12: After reset `sdo_oe` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (valid when sdo_oe is 1) |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command code (see R3) |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | 16 | Write data |
| rd_addr | output | ADDR_W | Read address presented to memory |
| rd_data | input | 16 | Memory word, valid one clock after rd_addr |
| wr_allowed | input | 1 | Executor write-enable state |
| busy | input | 1 | Executor busy flag for ready/busy output |

## Verification
The case where two functions meet is the rising edge that both ends the ready/busy output and starts shifting the next op-code. The same edge must turn off `sdo_oe` and load the captured 1 as op-code bit 15. The bench provokes this by keeping chip select low after a permitted write and then clocking in a write-enable op-code. It checks that `sdo_oe` is 0 after the first bit. It also checks that exactly one write-enable command appears after the 16th bit, which shows that the leading 1 was counted and not lost. A second case is the read word boundary, where loading the next word and advancing `rd_addr` happen on the same falling edge. It is judged by the word values across the wrap from address 8'hFF to 8'h00.

// File: rtl/sif_pkg.sv
package sif_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_WREN  = 3'd2,
        CMD_WRDS  = 3'd3,
        CMD_PDEN  = 3'd4,
        CMD_PDDS  = 3'd5,
        CMD_CALL  = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_DATA,
        ST_READ,
        ST_STATUS,
        ST_SKIP
    } state_e;

    localparam logic [7:0] OPC_READ  = 8'hA8;
    localparam logic [7:0] OPC_WRITE = 8'hA4;
    localparam logic [7:0] OPC_WREN  = 8'hA3;
    localparam logic [7:0] OPC_WRDS  = 8'hA0;
    localparam logic [7:0] OPC_PDEN  = 8'hAC;
    localparam logic [7:0] OPC_PDDS  = 8'hA6;
    localparam logic [7:0] OPC_CALL  = 8'hA2;

    localparam int FIELD_W = 16;

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], async_in[i]};
        end
        assign sync_out[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/sif_decode.sv
module sif_decode
    import sif_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       known,
    output cmd_e       op
);
    always_comb begin
        known = 1'b1;
        op    = CMD_READ;
        case (opcode)
            OPC_READ:  op = CMD_READ;
            OPC_WRITE: op = CMD_WRITE;
            OPC_WREN:  op = CMD_WREN;
            OPC_WRDS:  op = CMD_WRDS;
            OPC_PDEN:  op = CMD_PDEN;
            OPC_PDDS:  op = CMD_PDDS;
            OPC_CALL:  op = CMD_CALL;
            default:   known = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
    import sif_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [15:0]       cmd_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    input  logic              wr_allowed,
    input  logic              busy
);
    localparam int CNT_W = $clog2(FIELD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FIELD_W - 1);

    logic cs_s, sclk_s, sdi_s, sclk_d;
    logic rise, fall;

    sif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk, sdi}),
        .sync_out ({cs_s, sclk_s, sdi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end
    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    state_e                state_q, state_n;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FIELD_W-2:0]    hdr_sh, dat_sh;
    logic [FIELD_W-1:0]    next_hdr, next_dat, out_sh;
    logic [CNT_W-1:0]      rd_phase;
    logic                  rd_live;
    logic                  op_known;
    cmd_e                  op_dec, cmd_q;
    logic [ADDR_W-1:0]     hdr_addr, rd_addr_q;
    logic                  field_done;

    assign next_hdr   = {hdr_sh, sdi_s};
    assign next_dat   = {dat_sh, sdi_s};
    assign hdr_addr   = next_hdr[7 -: ADDR_W];
    assign field_done = rise && (bit_cnt == LAST_BIT);

    sif_decode u_dec (
        .opcode (next_hdr[15:8]),
        .known  (op_known),
        .op     (op_dec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (cs_s) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_n = ST_HEADER;
                ST_HEADER: if (field_done) begin
                               if (!op_known)               state_n = ST_SKIP;
                               else if (op_dec == CMD_READ)  state_n = ST_READ;
                               else if (op_dec == CMD_WRITE) state_n = ST_DATA;
                               else                          state_n = ST_SKIP;
                           end
                ST_DATA:   if (field_done) state_n = wr_allowed ? ST_STATUS : ST_SKIP;
                ST_STATUS: if (rise && sdi_s) state_n = ST_HEADER;
                ST_READ,
                ST_SKIP:   state_n = state_q;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            hdr_sh    <= '0;
            dat_sh    <= '0;
            out_sh    <= '0;
            rd_phase  <= '0;
            rd_live   <= 1'b0;
            rd_addr_q <= '0;
            cmd_valid <= 1'b0;
            cmd_q     <= CMD_READ;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_s || state_q == ST_IDLE) begin
                bit_cnt <= '0;
                rd_live <= 1'b0;
            end else begin
                case (state_q)
                    ST_HEADER: if (rise) begin
                        hdr_sh  <= next_hdr[FIELD_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (field_done && op_known && op_dec != CMD_WRITE) begin
                            cmd_valid <= 1'b1;
                            cmd_q     <= op_dec;
                            cmd_addr  <= hdr_addr;
                            if (op_dec == CMD_READ) begin
                                rd_addr_q <= hdr_addr;
                                rd_phase  <= '0;
                            end
                        end
                    end
                    ST_DATA: if (rise) begin
                        dat_sh  <= next_dat[FIELD_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (field_done) begin
                            cmd_valid <= 1'b1;
                            cmd_q     <= CMD_WRITE;
                            cmd_addr  <= hdr_sh[7 -: ADDR_W];
                            cmd_data  <= next_dat;
                        end
                    end
                    ST_READ: if (fall) begin
                        rd_live  <= 1'b1;
                        rd_phase <= rd_phase + 1'b1;
                        if (rd_phase == '0) begin
                            out_sh    <= rd_data;
                            rd_addr_q <= rd_addr_q + 1'b1;
                        end else begin
                            out_sh <= {out_sh[FIELD_W-2:0], 1'b0};
                        end
                    end
                    ST_STATUS: if (rise && sdi_s) begin
                        hdr_sh  <= {{(FIELD_W-2){1'b0}}, 1'b1};
                        bit_cnt <= CNT_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sdo_oe = 1'b0;
        sdo    = 1'b0;
        unique case (state_q)
            ST_READ:   begin sdo_oe = rd_live; sdo = out_sh[FIELD_W-1]; end
            ST_STATUS: begin sdo_oe = 1'b1;    sdo = ~busy;             end
            default:   ;
        endcase
    end

    assign cmd_op  = cmd_q;
    assign rd_addr = rd_addr_q;

endmodule

// File: rtl/sif_chk.sv
module sif_chk #(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] rd_addr
);
    localparam int HI_LIMIT = SYNC_STAGES + 2;
    int unsigned cs_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cs_hi_cnt <= 0;
        else if (!cs_n)                cs_hi_cnt <= 0;
        else if (cs_hi_cnt < HI_LIMIT) cs_hi_cnt <= cs_hi_cnt + 1;
    end

    // R11
    cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= HI_LIMIT) |-> !sdo_oe);

    // R11
    cs_high_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= HI_LIMIT) |-> !cmd_valid);

    // R3
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)) || cmd_valid);

    // R6
    sdo_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !$isunknown(sdo));

endmodule

bind serial_cmd_if sif_chk #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .cmd_valid (cmd_valid),
    .rd_addr   (rd_addr)
);

// File: tb/tb_serial_cmd_if.sv
`timescale 1ns/1ps
module tb_serial_cmd_if;
    localparam int AW   = 8;
    localparam int HALF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe, cmd_valid;
    logic [2:0] cmd_op;
    logic [AW-1:0] cmd_addr, rd_addr;
    logic [15:0] cmd_data, rd_data;
    logic wr_allowed = 1'b0, busy = 1'b0;

    int checks = 0, errors = 0;
    int cmd_cnt = 0;
    logic [2:0] last_op;
    logic [AW-1:0] last_addr;
    logic [15:0] last_data;

    always #2.5 clk = ~clk;

    serial_cmd_if #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_allowed(wr_allowed), .busy(busy)
    );

    // memory model: word = {addr, ~addr}, one clock latency
    always @(posedge clk) rd_data <= {rd_addr, ~rd_addr};

    always @(negedge clk) if (rst_n && cmd_valid) begin
        cmd_cnt   <= cmd_cnt + 1;
        last_op   <= cmd_op;
        last_addr <= cmd_addr;
        last_data <= cmd_data;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; sdi = v[i]; #HALF;
            sclk = 1'b1; #HALF;
        end
    endtask

    task automatic read_word(output logic [15:0] w, output bit oe_all);
        oe_all = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b0; #HALF;
            w[i] = sdo;
            oe_all &= sdo_oe;
            sclk = 1'b1; #HALF;
        end
    endtask

    task automatic cs_low();  cs_n = 1'b0; #HALF; endtask
    task automatic cs_high(); cs_n = 1'b1; sdi = 1'b0; #(4*HALF); endtask

    // {opcode, addr, fires, expected op code, expected addr}
    localparam logic [27:0] VEC [0:7] = '{
        {8'hA3, 8'h55, 1'b1, 3'd2, 8'h55},
        {8'hA0, 8'h00, 1'b1, 3'd3, 8'h00},
        {8'hAC, 8'h12, 1'b1, 3'd4, 8'h12},
        {8'hA6, 8'hFF, 1'b1, 3'd5, 8'hFF},
        {8'hA2, 8'h35, 1'b1, 3'd6, 8'h35},
        {8'hAF, 8'h00, 1'b0, 3'd0, 8'h00},
        {8'h12, 8'h00, 1'b0, 3'd0, 8'h00},
        {8'hA1, 8'h00, 1'b0, 3'd0, 8'h00}
    };

    bit done = 1'b0;

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [27:0] v;
        logic [15:0] w;
        bit oe_all;
        int base;

        #100; rst_n = 1'b1; #100;
        // R12 reset state
        check(sdo_oe == 1'b0, "R12 sdo_oe after reset", sdo_oe, 0);
        check(cmd_cnt == 0, "R12 no command after reset", cmd_cnt, 0);

        // R3 R4 R5 table walk: 32-bit frames, trailing bits must do nothing
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            base = cmd_cnt;
            cs_low();
            send_bits({v[27:12], 16'hBEEF}, 32);
            cs_high();
            check(cmd_cnt - base == int'(v[11]), "R4/R5 command count", cmd_cnt - base, v[11]);
            if (v[11]) begin
                check(last_op == v[10:8], "R3 op code", last_op, v[10:8]);
                check(last_addr == v[7:0], "R2 address field", last_addr, v[7:0]);
            end
        end

        // R6 read start and MSB-first output; R1 output on falling edges
        base = cmd_cnt;
        cs_low();
        send_bits(32'hA810, 16);
        check(sdo_oe == 1'b0, "R6 high-Z through 16th fall", sdo_oe, 0);
        check(cmd_cnt - base == 1 && last_op == 3'd0, "R3 read command strobe", last_op, 0);
        read_word(w, oe_all);
        check(oe_all, "R6 driven from 17th fall", oe_all, 1);
        check(w == 16'h10EF, "R6 R1 first read word", w, 16'h10EF);
        read_word(w, oe_all);
        check(w == 16'h11EE, "R7 sequential word", w, 16'h11EE);
        cs_high();
        check(sdo_oe == 1'b0, "R11 oe off after cs high", sdo_oe, 0);

        // R7 wrap from top address
        cs_low();
        send_bits(32'hA8FF, 16);
        read_word(w, oe_all);
        check(w == 16'hFF00, "R7 top address word", w, 16'hFF00);
        read_word(w, oe_all);
        check(w == 16'h00FF, "R7 wrap to zero", w, 16'h00FF);
        cs_high();

        // R8 permitted write with ready/busy
        wr_allowed = 1'b1; busy = 1'b1;
        base = cmd_cnt;
        cs_low();
        send_bits(32'hA4201234, 32);
        check(cmd_cnt - base == 1 && last_op == 3'd1, "R8 write strobe", last_op, 1);
        check(last_addr == 8'h20, "R8 write address", last_addr, 8'h20);
        check(last_data == 16'h1234, "R8 write data", last_data, 16'h1234);
        check(sdo_oe == 1'b1 && sdo == 1'b0, "R8 busy shown low", {sdo_oe, sdo}, 2'b10);
        busy = 1'b0; #HALF;
        check(sdo == 1'b1, "R8 ready shown high", sdo, 1);
        cs_high();
        check(sdo_oe == 1'b0, "R9 status ends on cs high", sdo_oe, 0);

        // R9 leading 1 of next op-code ends status and is kept as bit 15
        base = cmd_cnt;
        cs_low();
        send_bits(32'hA4215678, 32);
        check(sdo_oe == 1'b1, "R8 status shown", sdo_oe, 1);
        send_bits(32'h1, 1);
        check(sdo_oe == 1'b0, "R9 status ends on leading 1", sdo_oe, 0);
        send_bits(32'h2300, 15);
        check(cmd_cnt - base == 2 && last_op == 3'd2, "R9 following write-enable decoded", last_op, 2);
        cs_high();

        // R10 write while not permitted
        wr_allowed = 1'b0;
        base = cmd_cnt;
        cs_low();
        send_bits(32'hA400ABCD, 32);
        check(cmd_cnt - base == 1 && last_data == 16'hABCD, "R10 write still strobed", last_data, 16'hABCD);
        check(sdo_oe == 1'b0, "R10 no ready/busy", sdo_oe, 0);
        cs_high();

        // R11 partial frame abort
        base = cmd_cnt;
        cs_low();
        send_bits(32'h2A3, 10);
        cs_high();
        check(cmd_cnt == base, "R11 partial frame no command", cmd_cnt - base, 0);
        cs_low();
        send_bits(32'hA000, 16);
        cs_high();
        check(cmd_cnt - base == 1 && last_op == 3'd3, "R11 next frame decodes cleanly", last_op, 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule